// File: doc/BRIEF.md
# PCI Bus-Master DMA Controller

This block sits between software-visible control registers and the master-side request interface of a PCI core. Software loads a read address, a write address, read and write word counts, and a control word that carries the PCI command for each direction, an arbitration policy, interrupt enables and a burst length. A start bit then marks a direction as pending. The controller chooses between pending read and write jobs and raises a burst request with the job's command. It advances the PCI address and the remaining word count as beats are reported, and it splits the job into bursts no longer than the burst length. For read bursts it signals how many beats are left.

The core never inserts wait states, so the controller has to observe the core's timing rules. The request falls on the edge that counts the last beat of a burst, which is the second clock after that beat moved on the bus. Write beats are counted on the core's one-cycle-delayed transfer strobe and read beats on the read-data-valid strobe. A new burst, or the end of the job, waits for the core's single-cycle completion pulse. A target abort or a master abort ends the job at once and is recorded in sticky status. Status bits combined with their enables drive an interrupt.

Top module: `dma_master_ctrl`

## Requirements
- R1: Register word indices are 0 read address, 1 write address, 2 lengths (read count in bits 15:0, write count in bits 31:16), 3 control, 4 status. Control holds bit 0 read start, bit 1 write start, bits 3:2 policy, bits 7:4 read command, bits 11:8 write command, bits 14:12 interrupt enables (done, target abort, master abort), bits 23:16 burst length. Written values read back, and the start bits read back as 0.
- R2: The request stays high from the grant until the edge that counts the last beat of a burst and falls right after that edge. A job of N words with burst length B (0 meaning unlimited) produces ceil(N/B) request episodes, and each episode after the first follows a completion pulse.
- R3: While the request is high, the command output equals the read command field for a read job and the write command field for a write job, and it does not change.
- R4: The write address advances by 4 on each delayed transfer strobe of a write burst, and the read address advances by 4 on each read-data-valid of a read burst. Consecutive beats therefore use consecutive word addresses starting at the programmed base.
- R5: The remaining count of the active direction drops by one per counted beat and reads 0 when the job has completed.
- R6: During a read burst, two-left is high while exactly two beats of the current burst remain and one-left is high while exactly one remains. A one-word read burst has one-left high from the first cycle of its request. Both stay low for write jobs.
- R7: Status bit 0 (done) is set when the completion pulse of the final burst arrives. Status bits are sticky, writing 1 clears them, and writing 0 leaves them unchanged.
- R8: A target-abort or master-abort indication during a job drops the request on the next edge, sets status bit 1 or bit 2 respectively, and cancels the job so that no further request follows.
- R9: With both directions pending, policy 1 serves the read job first and policy 2 serves the write job first. Policy 0 serves the direction that was not served last.
- R10: The interrupt output is high exactly when some status bit is set together with its enable bit.
- R11: A start bit written while that direction's count is 0 is ignored: no request is raised and no status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| core_xfer_d1 | input | 1 | Core: a beat moved on the bus in the previous cycle |
| core_rd_valid | input | 1 | Core: read data handed to the backend |
| core_wr_done | input | 1 | Core: write burst finished (single-cycle pulse) |
| core_rd_done | input | 1 | Core: read burst finished (single-cycle pulse) |
| core_tgt_abort | input | 1 | Core: target abort seen |
| core_mst_abort | input | 1 | Core: no target responded (master abort) |
| mst_req | output | 1 | Burst request to the core |
| mst_cmd | output | 4 | PCI command for the burst |
| mst_wr_addr | output | 32 | Current PCI write address |
| mst_rd_addr | output | 32 | Current PCI read address |
| mst_one_left | output | 1 | One read beat of the burst remains |
| mst_two_left | output | 1 | Two read beats of the burst remains |
| irq | output | 1 | Interrupt request |

## Verification
A bench model of the core answers each request with back-to-back beats and a completion pulse. A scoreboard predicts the address, command and lookahead flags of every beat. Jobs are run as a single unlimited read, a write split into uneven bursts, a one-word read, and a read split 2-2-1. These separate address stepping, burst reload and the lookahead edge cases. Paired jobs under each policy show whether arbitration follows the policy or only the order of the start bits. Injected target and master aborts, and a start with a count of zero, show whether a job can be cancelled or refused without stray requests or status bits.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    REG_RD_ADDR = 3'd0,
    REG_WR_ADDR = 3'd1,
    REG_LEN     = 3'd2,
    REG_CTRL    = 3'd3,
    REG_STAT    = 3'd4
  } reg_idx_e;

  typedef enum logic [1:0] {
    ARB_ROUND    = 2'd0,
    ARB_RD_FIRST = 2'd1,
    ARB_WR_FIRST = 2'd2,
    ARB_ROUND_B  = 2'd3
  } arb_pol_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_BURST = 2'd1,
    ENG_DRAIN = 2'd2
  } eng_state_e;

  localparam int unsigned ST_DONE   = 0;
  localparam int unsigned ST_TABORT = 1;
  localparam int unsigned ST_MABORT = 2;
  localparam int unsigned ST_W      = 3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned BL_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              rd_inc,
  input  logic              wr_inc,
  input  logic              ev_done,
  input  logic              ev_tab,
  input  logic              ev_mab,
  input  logic              grant_rd,
  input  logic              grant_wr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  rd_len,
  output logic [LEN_W-1:0]  wr_len,
  output logic [1:0]        policy,
  output logic [3:0]        rd_cmd,
  output logic [3:0]        wr_cmd,
  output logic [BL_W-1:0]   burst_len,
  output logic              rd_pend,
  output logic              wr_pend,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] rd_addr_d, wr_addr_d;
  logic [LEN_W-1:0]  rd_len_d, wr_len_d;
  logic [1:0]        pol_d;
  logic [3:0]        rcmd_d, wcmd_d;
  logic [ST_W-1:0]   en_q, en_d, st_q, st_d;
  logic [BL_W-1:0]   bl_d;
  logic              rp_d, wp_d;
  logic              wr_ctrl;
  logic              unused_bits;

  assign unused_bits = ^{wdata[31:24], wdata[15]};
  assign wr_ctrl = wr_en && (addr == REG_CTRL);

  always_comb begin
    rd_addr_d = rd_addr;
    wr_addr_d = wr_addr;
    rd_len_d  = rd_len;
    wr_len_d  = wr_len;
    pol_d     = policy;
    rcmd_d    = rd_cmd;
    wcmd_d    = wr_cmd;
    en_d      = en_q;
    bl_d      = burst_len;
    rp_d      = rd_pend && !grant_rd;
    wp_d      = wr_pend && !grant_wr;
    st_d      = st_q;
    if (wr_en && addr == REG_RD_ADDR) rd_addr_d = wdata[ADDR_W-1:0];
    else if (rd_inc)                  rd_addr_d = rd_addr + STEP;
    if (wr_en && addr == REG_WR_ADDR) wr_addr_d = wdata[ADDR_W-1:0];
    else if (wr_inc)                  wr_addr_d = wr_addr + STEP;
    if (wr_en && addr == REG_LEN) begin
      rd_len_d = wdata[LEN_W-1:0];
      wr_len_d = wdata[16 +: LEN_W];
    end else begin
      if (rd_inc) rd_len_d = rd_len - 1'b1;
      if (wr_inc) wr_len_d = wr_len - 1'b1;
    end
    if (wr_ctrl) begin
      pol_d  = wdata[3:2];
      rcmd_d = wdata[7:4];
      wcmd_d = wdata[11:8];
      en_d   = wdata[14:12];
      bl_d   = wdata[16 +: BL_W];
      if (wdata[0] && rd_len != '0) rp_d = 1'b1;
      if (wdata[1] && wr_len != '0) wp_d = 1'b1;
    end
    if (wr_en && addr == REG_STAT) st_d = st_q & ~wdata[ST_W-1:0];
    st_d[ST_DONE]   = st_d[ST_DONE]   | ev_done;
    st_d[ST_TABORT] = st_d[ST_TABORT] | ev_tab;
    st_d[ST_MABORT] = st_d[ST_MABORT] | ev_mab;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr <= '0; wr_addr <= '0; rd_len <= '0; wr_len <= '0;
      policy <= '0; rd_cmd <= '0; wr_cmd <= '0; en_q <= '0;
      burst_len <= '0; rd_pend <= 1'b0; wr_pend <= 1'b0; st_q <= '0;
    end else begin
      rd_addr <= rd_addr_d; wr_addr <= wr_addr_d;
      rd_len <= rd_len_d; wr_len <= wr_len_d;
      policy <= pol_d; rd_cmd <= rcmd_d; wr_cmd <= wcmd_d; en_q <= en_d;
      burst_len <= bl_d; rd_pend <= rp_d; wr_pend <= wp_d; st_q <= st_d;
    end
  end

  assign irq = |(st_q & en_q);

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_RD_ADDR: rdata[ADDR_W-1:0] = rd_addr;
      REG_WR_ADDR: rdata[ADDR_W-1:0] = wr_addr;
      REG_LEN: begin
        rdata[LEN_W-1:0]   = rd_len;
        rdata[16 +: LEN_W] = wr_len;
      end
      REG_CTRL: begin
        rdata[3:2]        = policy;
        rdata[7:4]        = rd_cmd;
        rdata[11:8]       = wr_cmd;
        rdata[14:12]      = en_q;
        rdata[16 +: BL_W] = burst_len;
      end
      REG_STAT: rdata[ST_W-1:0] = st_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idle,
  input  logic       rd_pend,
  input  logic       wr_pend,
  input  logic [1:0] policy,
  output logic       grant_rd,
  output logic       grant_wr
);
  logic prev_rd_q, prev_rd_d, pick_rd;

  always_comb begin
    unique case (arb_pol_e'(policy))
      ARB_RD_FIRST: pick_rd = rd_pend;
      ARB_WR_FIRST: pick_rd = rd_pend && !wr_pend;
      default:      pick_rd = rd_pend && (!wr_pend || !prev_rd_q);
    endcase
    grant_rd  = idle && pick_rd;
    grant_wr  = idle && wr_pend && !pick_rd;
    prev_rd_d = prev_rd_q;
    if (grant_rd)      prev_rd_d = 1'b1;
    else if (grant_wr) prev_rd_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_rd_q <= 1'b0;
    else        prev_rd_q <= prev_rd_d;
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned BL_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_rd,
  input  logic             grant_wr,
  input  logic [LEN_W-1:0] rd_len,
  input  logic [LEN_W-1:0] wr_len,
  input  logic [BL_W-1:0]  burst_len,
  input  logic [3:0]       rd_cmd,
  input  logic [3:0]       wr_cmd,
  input  logic             xfer_d1,
  input  logic             rd_valid,
  input  logic             wr_done,
  input  logic             rd_done,
  input  logic             tgt_abort,
  input  logic             mst_abort,
  output logic             idle,
  output logic             req,
  output logic [3:0]       cmd,
  output logic             rd_inc,
  output logic             wr_inc,
  output logic             one_left,
  output logic             two_left,
  output logic             ev_done,
  output logic             ev_tab,
  output logic             ev_mab
);
  eng_state_e       state_q, state_d;
  logic             is_rd_q, is_rd_d;
  logic [LEN_W-1:0] left_q, left_d, rem;
  logic [3:0]       cmd_q, cmd_d;
  logic             in_burst, beat, fin;

  function automatic logic [LEN_W-1:0] chunk(input logic [LEN_W-1:0] len,
                                             input logic [BL_W-1:0]  bl);
    logic [LEN_W-1:0] blx;
    blx = LEN_W'(bl);
    return (bl == '0 || len <= blx) ? len : blx;
  endfunction

  assign in_burst = (state_q == ENG_BURST);
  assign beat     = in_burst && (is_rd_q ? rd_valid : xfer_d1);
  assign fin      = is_rd_q ? rd_done : wr_done;
  assign rem      = is_rd_q ? rd_len : wr_len;
  assign rd_inc   = beat && is_rd_q;
  assign wr_inc   = beat && !is_rd_q;

  always_comb begin
    state_d = state_q;
    is_rd_d = is_rd_q;
    left_d  = left_q;
    cmd_d   = cmd_q;
    ev_done = 1'b0;
    ev_tab  = 1'b0;
    ev_mab  = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        if (grant_rd || grant_wr) begin
          is_rd_d = grant_rd;
          cmd_d   = grant_rd ? rd_cmd : wr_cmd;
          left_d  = chunk(grant_rd ? rd_len : wr_len, burst_len);
          if (left_d == '0) ev_done = 1'b1;
          else              state_d = ENG_BURST;
        end
      end
      ENG_BURST, ENG_DRAIN: begin
        if (tgt_abort || mst_abort) begin
          ev_tab  = tgt_abort;
          ev_mab  = mst_abort && !tgt_abort;
          state_d = ENG_IDLE;
        end else if (in_burst) begin
          if (beat) begin
            left_d = left_q - 1'b1;
            if (left_q == LEN_W'(1)) state_d = ENG_DRAIN;
          end
        end else if (fin) begin
          if (rem == '0) begin
            ev_done = 1'b1;
            state_d = ENG_IDLE;
          end else begin
            left_d  = chunk(rem, burst_len);
            state_d = ENG_BURST;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      is_rd_q <= 1'b0;
      left_q  <= '0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      is_rd_q <= is_rd_d;
      left_q  <= left_d;
      cmd_q   <= cmd_d;
    end
  end

  assign idle     = (state_q == ENG_IDLE);
  assign req      = in_burst;
  assign cmd      = cmd_q;
  assign one_left = in_burst && is_rd_q && (left_q == LEN_W'(1));
  assign two_left = in_burst && is_rd_q && (left_q == LEN_W'(2));
endmodule

// File: rtl/dma_master_ctrl.sv
module dma_master_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned BL_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              core_xfer_d1,
  input  logic              core_rd_valid,
  input  logic              core_wr_done,
  input  logic              core_rd_done,
  input  logic              core_tgt_abort,
  input  logic              core_mst_abort,
  output logic              mst_req,
  output logic [3:0]        mst_cmd,
  output logic [ADDR_W-1:0] mst_wr_addr,
  output logic [ADDR_W-1:0] mst_rd_addr,
  output logic              mst_one_left,
  output logic              mst_two_left,
  output logic              irq
);
  logic [LEN_W-1:0] rd_len, wr_len;
  logic [BL_W-1:0]  burst_len;
  logic [1:0]       policy;
  logic [3:0]       rd_cmd, wr_cmd;
  logic rd_pend, wr_pend, grant_rd, grant_wr, idle;
  logic rd_inc, wr_inc, ev_done, ev_tab, ev_mab;

  dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BL_W(BL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .rd_inc(rd_inc), .wr_inc(wr_inc),
    .ev_done(ev_done), .ev_tab(ev_tab), .ev_mab(ev_mab),
    .grant_rd(grant_rd), .grant_wr(grant_wr),
    .rd_addr(mst_rd_addr), .wr_addr(mst_wr_addr), .rd_len(rd_len), .wr_len(wr_len),
    .policy(policy), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .burst_len(burst_len),
    .rd_pend(rd_pend), .wr_pend(wr_pend), .irq(irq)
  );

  dma_arb u_arb (
    .clk(clk), .rst_n(rst_n), .idle(idle), .rd_pend(rd_pend), .wr_pend(wr_pend),
    .policy(policy), .grant_rd(grant_rd), .grant_wr(grant_wr)
  );

  dma_engine #(.LEN_W(LEN_W), .BL_W(BL_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .grant_rd(grant_rd), .grant_wr(grant_wr),
    .rd_len(rd_len), .wr_len(wr_len), .burst_len(burst_len),
    .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .xfer_d1(core_xfer_d1),
    .rd_valid(core_rd_valid), .wr_done(core_wr_done), .rd_done(core_rd_done),
    .tgt_abort(core_tgt_abort), .mst_abort(core_mst_abort), .idle(idle),
    .req(mst_req), .cmd(mst_cmd), .rd_inc(rd_inc), .wr_inc(wr_inc),
    .one_left(mst_one_left), .two_left(mst_two_left),
    .ev_done(ev_done), .ev_tab(ev_tab), .ev_mab(ev_mab)
  );
endmodule

// File: rtl/dma_master_ctrl_chk.sv
module dma_master_ctrl_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic              core_xfer_d1,
  input logic              core_rd_valid,
  input logic              core_tgt_abort,
  input logic              core_mst_abort,
  input logic              mst_req,
  input logic [3:0]        mst_cmd,
  input logic [ADDR_W-1:0] mst_wr_addr,
  input logic [ADDR_W-1:0] mst_rd_addr,
  input logic              mst_one_left,
  input logic              mst_two_left
);
  AST_CMD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && $past(mst_req)) |-> $stable(mst_cmd)); // R3

  AST_REQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_req) |-> ($past(core_xfer_d1) || $past(core_rd_valid) ||
                        $past(core_tgt_abort) || $past(core_mst_abort))); // R2

  AST_ABORT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_req && (core_tgt_abort || core_mst_abort)) |=> !mst_req); // R8

  AST_LOOKAHEAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_one_left || mst_two_left) |-> (mst_req && !(mst_one_left && mst_two_left))); // R6

  AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr_en) && !$past(core_xfer_d1)) |-> $stable(mst_wr_addr)); // R4

  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr_en) && !$past(core_rd_valid)) |-> $stable(mst_rd_addr)); // R4
endmodule

bind dma_master_ctrl dma_master_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en),
  .core_xfer_d1(core_xfer_d1), .core_rd_valid(core_rd_valid),
  .core_tgt_abort(core_tgt_abort), .core_mst_abort(core_mst_abort),
  .mst_req(mst_req), .mst_cmd(mst_cmd), .mst_wr_addr(mst_wr_addr),
  .mst_rd_addr(mst_rd_addr), .mst_one_left(mst_one_left), .mst_two_left(mst_two_left)
);

// File: tb/dma_master_ctrl_test.sv
module dma_master_ctrl_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, reg_wr_en;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic core_xfer_d1, core_rd_valid, core_wr_done, core_rd_done, core_tgt_abort, core_mst_abort;
  logic        mst_req, mst_one_left, mst_two_left, irq;
  logic [3:0]  mst_cmd;
  logic [31:0] mst_wr_addr, mst_rd_addr;

  dma_master_ctrl uut (.*);

  typedef struct { logic [31:0] addr; logic [3:0] cmd; logic one; logic two; } beat_t;
  beat_t sb[$];
  int n_tests = 0, n_fail = 0, req_rises = 0, age = 0, base;
  bit prev_req = 0, last_rd = 0, ab_last = 0, inj_tab = 0, inj_mab = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrl(bit gr, bit gw, logic [1:0] pol, logic [3:0] rc,
                                       logic [3:0] wc, logic [2:0] en, logic [7:0] bl);
    return {8'h00, bl, 1'b0, en, wc, rc, pol, gw, gr};
  endfunction

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  // driver: push one expected item per beat of a job
  task automatic expect_job(bit is_rd, logic [31:0] base_a, int len, int bl, logic [3:0] c);
    logic [31:0] a = base_a;
    int rem = len;
    while (rem > 0) begin
      int n = (bl == 0 || rem <= bl) ? rem : bl;
      for (int k = n; k >= 1; k--) begin
        beat_t e;
        e.addr = a; e.cmd = c; e.one = is_rd && k == 1; e.two = is_rd && k == 2;
        sb.push_back(e);
        a += 32'd4;
      end
      rem -= n;
    end
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (sb.size() != 0 || mst_req) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // core model and monitor: answers requests with beats, compares each beat
  always @(negedge clk) begin : core_model
    core_xfer_d1 = 0; core_rd_valid = 0; core_wr_done = 0; core_rd_done = 0;
    core_tgt_abort = 0; core_mst_abort = 0;
    if (!rst_n) begin
      age = 0; prev_req = 0;
    end else begin
      if (mst_req) begin
        if (!prev_req) req_rises++;
        age++;
        last_rd = !mst_cmd[0];
        if (age == 3 && (inj_tab || inj_mab)) begin
          core_tgt_abort = inj_tab; core_mst_abort = inj_mab;
          inj_tab = 0; inj_mab = 0; ab_last = 1;
        end else if (age >= 2) begin
          if (sb.size() == 0) chk("R2 unexpected beat", 32'd1, 32'd0);
          else begin
            beat_t e;
            e = sb.pop_front();
            chk("R4 beat address", mst_rd_addr & {32{last_rd}} | mst_wr_addr & {32{!last_rd}}, e.addr);
            chk("R3 beat command", {28'd0, mst_cmd}, {28'd0, e.cmd});
            chk("R6 lookahead one/two", {30'd0, mst_one_left, mst_two_left}, {30'd0, e.one, e.two});
          end
          if (last_rd) core_rd_valid = 1; else core_xfer_d1 = 1;
        end
      end else begin
        age = 0;
        if (prev_req && !ab_last) begin
          if (last_rd) core_rd_done = 1; else core_wr_done = 1;
        end
        ab_last = 0;
      end
      prev_req = mst_req;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset req", {31'd0, mst_req}, 0);
    chk("R10 reset irq", {31'd0, irq}, 0);
    rd_chk(3'd4, 0, "R7 reset status");
    rd_chk(3'd0, 0, "R1 reset read address");

    // R11: start with zero counts is ignored
    wr_reg(3'd2, 0);
    wr_reg(3'd3, ctrl(1, 1, 0, 4'h6, 4'h7, 3'b001, 0));
    repeat (10) @(negedge clk);
    chk("R11 no request on zero count", req_rises, 0);
    rd_chk(3'd4, 0, "R11 no status on zero count");

    // R1 readback
    wr_reg(3'd0, 32'h0000_1000);
    wr_reg(3'd1, 32'h8000_0000);
    wr_reg(3'd2, {16'd3, 16'd5});
    wr_reg(3'd3, ctrl(0, 0, 1, 4'h6, 4'h7, 3'b001, 0));
    rd_chk(3'd0, 32'h0000_1000, "R1 read address");
    rd_chk(3'd1, 32'h8000_0000, "R1 write address");
    rd_chk(3'd2, {16'd3, 16'd5}, "R1 lengths");
    rd_chk(3'd3, ctrl(0, 0, 1, 4'h6, 4'h7, 3'b001, 0), "R1 control");

    // unlimited read of 5 words
    expect_job(1, 32'h1000, 5, 0, 4'h6);
    base = req_rises;
    wr_reg(3'd3, ctrl(1, 0, 1, 4'h6, 4'h7, 3'b001, 0));
    wait_done();
    chk("R2 one episode", req_rises - base, 1);
    rd_chk(3'd4, 1, "R7 done set");
    chk("R10 irq on done", {31'd0, irq}, 1);
    rd_chk(3'd2, {16'd3, 16'd0}, "R5 read count zero");
    rd_chk(3'd0, 32'h0000_1014, "R4 read address end");
    rd_chk(3'd3, ctrl(0, 0, 1, 4'h6, 4'h7, 3'b001, 0), "R1 start bits read 0");
    wr_reg(3'd4, 0);
    rd_chk(3'd4, 1, "R7 write 0 keeps status");
    wr_reg(3'd4, 1);
    rd_chk(3'd4, 0, "R7 write 1 clears");
    chk("R10 irq cleared", {31'd0, irq}, 0);

    // write of 3 words in bursts of 2
    expect_job(0, 32'h8000_0000, 3, 2, 4'h7);
    base = req_rises;
    wr_reg(3'd3, ctrl(0, 1, 1, 4'h6, 4'h7, 3'b001, 2));
    wait_done();
    chk("R2 two episodes", req_rises - base, 2);
    rd_chk(3'd1, 32'h8000_000C, "R4 write address end");
    rd_chk(3'd2, 0, "R5 write count zero");
    rd_chk(3'd4, 1, "R7 done after bursts");
    wr_reg(3'd4, 7);

    // single-word read
    wr_reg(3'd0, 32'h2000);
    wr_reg(3'd2, 1);
    expect_job(1, 32'h2000, 1, 2, 4'h6);
    wr_reg(3'd3, ctrl(1, 0, 1, 4'h6, 4'h7, 3'b001, 2));
    while (!mst_req) @(negedge clk);
    #1;
    chk("R6 one-left with request", {30'd0, mst_one_left, mst_two_left}, 32'd2);
    wait_done();

    // read 5 words split 2-2-1 with another command
    wr_reg(3'd0, 32'h3000);
    wr_reg(3'd2, 5);
    expect_job(1, 32'h3000, 5, 2, 4'hC);
    base = req_rises;
    wr_reg(3'd3, ctrl(1, 0, 1, 4'hC, 4'h7, 3'b001, 2));
    wait_done();
    chk("R2 three episodes", req_rises - base, 3);

    // R9 read first
    wr_reg(3'd0, 32'h4000); wr_reg(3'd1, 32'h5000); wr_reg(3'd2, {16'd2, 16'd2});
    expect_job(1, 32'h4000, 2, 0, 4'h6);
    expect_job(0, 32'h5000, 2, 0, 4'h7);
    wr_reg(3'd3, ctrl(1, 1, 1, 4'h6, 4'h7, 3'b001, 0));
    wait_done();
    chk("R9 read-first order done", sb.size(), 0);

    // R9 write first
    wr_reg(3'd0, 32'h4100); wr_reg(3'd1, 32'h5100); wr_reg(3'd2, {16'd2, 16'd2});
    expect_job(0, 32'h5100, 2, 0, 4'h7);
    expect_job(1, 32'h4100, 2, 0, 4'h6);
    wr_reg(3'd3, ctrl(1, 1, 2, 4'h6, 4'h7, 3'b001, 0));
    wait_done();
    chk("R9 write-first order done", sb.size(), 0);

    // R9 round robin: read served last, so write goes first
    wr_reg(3'd0, 32'h4200); wr_reg(3'd1, 32'h5200); wr_reg(3'd2, {16'd1, 16'd3});
    expect_job(0, 32'h5200, 1, 0, 4'h7);
    expect_job(1, 32'h4200, 3, 0, 4'h6);
    wr_reg(3'd3, ctrl(1, 1, 0, 4'h6, 4'h7, 3'b001, 0));
    wait_done();
    chk("R9 round-robin order done", sb.size(), 0);
    wr_reg(3'd4, 7);

    // R8 target abort on a write
    wr_reg(3'd1, 32'h6000); wr_reg(3'd2, {16'd4, 16'd0});
    sb.push_back('{32'h6000, 4'h7, 1'b0, 1'b0});
    inj_tab = 1;
    base = req_rises;
    wr_reg(3'd3, ctrl(0, 1, 0, 4'h6, 4'h7, 3'b110, 0));
    wait_done();
    repeat (10) @(negedge clk);
    chk("R8 target abort ends job", req_rises - base, 1);
    rd_chk(3'd4, 2, "R8 target abort status");
    chk("R10 irq on target abort", {31'd0, irq}, 1);
    wr_reg(3'd4, 7);

    // R8 master abort on a read
    wr_reg(3'd0, 32'h7000); wr_reg(3'd2, {16'd0, 16'd4});
    sb.push_back('{32'h7000, 4'h6, 1'b0, 1'b0});
    inj_mab = 1;
    base = req_rises;
    wr_reg(3'd3, ctrl(1, 0, 0, 4'h6, 4'h7, 3'b100, 0));
    wait_done();
    repeat (10) @(negedge clk);
    chk("R8 master abort ends job", req_rises - base, 1);
    rd_chk(3'd4, 4, "R8 master abort status");
    chk("R10 irq on master abort", {31'd0, irq}, 1);
    wr_reg(3'd3, ctrl(0, 0, 0, 4'h6, 4'h7, 3'b011, 0));
    @(negedge clk);
    chk("R10 irq masked", {31'd0, irq}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule